// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves one virtual address into the physical address of its leaf translation entry. A walk begins from a root pointer that software has programmed. The walker reads a 32-bit entry from the first directory level and then one from the second level. Each nonzero entry is a compressed pointer: shifting it left by 11 bits gives the physical base of the next level. The walker then adds the scaled leaf index to that base and returns the result. It does not read the leaf entry itself.

If either directory entry is zero, the walk stops at that point. The block then reports a failure instead of a pointer. The walker uses a memory port with a valid/ready request and a valid response, and it keeps one request in flight at a time. A start pulse is taken only while the block is idle. Every walk ends with a one-cycle done pulse.

The virtual address is split into index fields that sit above a page offset. With the default parameters the offset is 13 bits. The leaf index is address bits 22:13, the second-level index is bits 33:23 and the first-level index is bits 44:34.

Top module: `pt_walker`

## Requirements
- R1: After reset, `idle_o` is 1, and `mem_req_valid_o` and `done_o` are 0.
- R2: A start pulse is accepted only when `idle_o` is 1. A start pulse during a walk has no effect: the request addresses and the result still come from the address and root that were latched at the accepted start, and no extra request is issued.
- R3: The first memory request address is root + first-level index × 4.
- R4: If the first entry E1 is nonzero, the second request address is (E1 << 11) + second-level index × 4.
- R5: If the second entry E2 is nonzero, the walk ends with `done_o`=1, `fail_o`=0 and `leaf_ptr_o` = (E2 << 11) + leaf index × 8. Exactly two requests are issued.
- R6: If E1 is zero, the walk ends with `done_o`=1, `fail_o`=1 and `leaf_ptr_o`=0, after exactly one request.
- R7: If E2 is zero, the walk ends with `done_o`=1, `fail_o`=1 and `leaf_ptr_o`=0, after exactly two requests.
- R8: A request that is not accepted stays valid, with the same address, until `mem_req_ready_i` is high. A new request is never raised while a response is still pending.
- R9: From the accepted start until the walk ends, `walk_va_o` holds the accepted virtual address unchanged.
- R10: `done_o` is a single-cycle pulse, and `fail_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk; honoured only while idle |
| vaddr_i | input | 64 | Virtual address to translate |
| root_i | input | 64 | Physical base of the first directory level |
| idle_o | output | 1 | High when a start would be accepted |
| walk_va_o | output | 64 | Virtual address latched for the current walk |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 64 | Physical byte address of the 32-bit read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Directory entry returned by memory |
| done_o | output | 1 | One-cycle walk completion pulse |
| fail_o | output | 1 | With done: the walk hit a zero entry |
| leaf_ptr_o | output | 64 | With done and no fail: physical address of the leaf entry |

## Verification
The assertions assume that memory returns exactly one response for each accepted request, and that no response arrives without a request. They also assume that `mem_rsp_valid_i` is a single-cycle pulse. The bench memory model follows these rules. It waits for a request, optionally holds `mem_req_ready_i` low for several cycles, accepts the request, and after a set latency drives one response pulse. It never raises a response on its own. Start pulses driven in the middle of a walk reach only the start input and never the memory side.

// File: rtl/pt_walk_pkg.sv
// Shared types for the page table walker.
// Assumes: nothing beyond IEEE 1800-2017.
package pt_walk_pkg;

    // Walk sequencing states: a request phase and a wait phase for each directory level.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ_L1  = 3'd1,
        ST_WAIT_L1 = 3'd2,
        ST_REQ_L2  = 3'd3,
        ST_WAIT_L2 = 3'd4
    } walk_st_e;

endpackage

// File: rtl/pt_walk_ctl.sv
// Walk sequencer. It steps through two directory reads, with one request
// outstanding at a time, and reports the end of a walk.
// Assumes: exactly one response per accepted request; rsp_valid is a pulse.
module pt_walk_ctl
    import pt_walk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     req_ready_i,
    input  logic     rsp_valid_i,
    input  logic     entry_zero_i,
    output logic     idle_o,
    output logic     req_valid_o,
    output logic     level2_o,
    output logic     load_o,
    output logic     take_base_o,
    output logic     finish_ok_o,
    output logic     finish_fail_o
);

    walk_st_e st_q, st_d;

    // Next-state selection for the walk sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start_i) st_d = ST_REQ_L1;
            ST_REQ_L1:  if (req_ready_i) st_d = ST_WAIT_L1;
            ST_WAIT_L1: if (rsp_valid_i) st_d = entry_zero_i ? ST_IDLE : ST_REQ_L2;
            ST_REQ_L2:  if (req_ready_i) st_d = ST_WAIT_L2;
            ST_WAIT_L2: if (rsp_valid_i) st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Decoded strobes that tell the datapath when to capture its values.
    always_comb begin
        idle_o        = (st_q == ST_IDLE);
        req_valid_o   = (st_q == ST_REQ_L1) || (st_q == ST_REQ_L2);
        level2_o      = (st_q == ST_REQ_L2) || (st_q == ST_WAIT_L2);
        load_o        = idle_o && start_i;
        take_base_o   = (st_q == ST_WAIT_L1) && rsp_valid_i && !entry_zero_i;
        finish_ok_o   = (st_q == ST_WAIT_L2) && rsp_valid_i && !entry_zero_i;
        finish_fail_o = ((st_q == ST_WAIT_L1) || (st_q == ST_WAIT_L2))
                        && rsp_valid_i && entry_zero_i;
    end

endmodule

// File: rtl/pt_walk_agen.sv
// Address generator. It forms the directory read addresses, the next-level
// base taken from a compressed entry, and the leaf entry pointer.
// Assumes: index fields already extracted; purely combinational.
module pt_walk_agen #(
    parameter int PA_W   = 64,
    parameter int ENT_W  = 32,
    parameter int L1_W   = 11,
    parameter int L2_W   = 11,
    parameter int L3_W   = 10,
    parameter int EXPAND = 11
) (
    input  logic [PA_W-1:0]  root_i,
    input  logic [PA_W-1:0]  base_i,
    input  logic             level2_i,
    input  logic [L1_W-1:0]  idx1_i,
    input  logic [L2_W-1:0]  idx2_i,
    input  logic [L3_W-1:0]  idx3_i,
    input  logic [ENT_W-1:0] entry_i,
    output logic [PA_W-1:0]  req_addr_o,
    output logic [PA_W-1:0]  next_base_o,
    output logic [PA_W-1:0]  leaf_ptr_o
);

    localparam int DIR_SCALE  = $clog2(ENT_W / 8);
    localparam int LEAF_SCALE = 3;

    logic [PA_W-1:0] dir_off, leaf_off, ent_base;

    // Offsets scaled by entry size and the widened entry base.
    always_comb begin
        dir_off  = level2_i ? ({{(PA_W-L2_W){1'b0}}, idx2_i} << DIR_SCALE)
                            : ({{(PA_W-L1_W){1'b0}}, idx1_i} << DIR_SCALE);
        leaf_off = {{(PA_W-L3_W){1'b0}}, idx3_i} << LEAF_SCALE;
        ent_base = {{(PA_W-ENT_W){1'b0}}, entry_i} << EXPAND;
    end

    // Final address sums.
    always_comb begin
        req_addr_o  = (level2_i ? base_i : root_i) + dir_off;
        next_base_o = ent_base;
        leaf_ptr_o  = ent_base + leaf_off;
    end

endmodule

// File: rtl/pt_walker.sv
// Top of the page table walker. It latches the virtual address and root on
// start, runs two directory reads and returns the leaf entry address or a
// failure, together with a done pulse.
// Assumes: memory returns one response per accepted request.
module pt_walker #(
    parameter int VA_W   = 64,
    parameter int PA_W   = 64,
    parameter int ENT_W  = 32,
    parameter int OFS_W  = 13,
    parameter int L1_W   = 11,
    parameter int L2_W   = 11,
    parameter int L3_W   = 10,
    parameter int EXPAND = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VA_W-1:0]  vaddr_i,
    input  logic [PA_W-1:0]  root_i,
    output logic             idle_o,
    output logic [VA_W-1:0]  walk_va_o,
    output logic             mem_req_valid_o,
    input  logic             mem_req_ready_i,
    output logic [PA_W-1:0]  mem_req_addr_o,
    input  logic             mem_rsp_valid_i,
    input  logic [ENT_W-1:0] mem_rsp_data_i,
    output logic             done_o,
    output logic             fail_o,
    output logic [PA_W-1:0]  leaf_ptr_o
);

    localparam int L3_LO = OFS_W;
    localparam int L2_LO = L3_LO + L3_W;
    localparam int L1_LO = L2_LO + L2_W;

    logic [VA_W-1:0] va_q;
    logic [PA_W-1:0] root_q, base_q, ptr_q, next_base, leaf_ptr;
    logic            done_q, fail_q;
    logic            level2, load, take_base, fin_ok, fin_fail, entry_zero;

    assign entry_zero = (mem_rsp_data_i == '0);

    pt_walk_ctl u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .req_ready_i   (mem_req_ready_i),
        .rsp_valid_i   (mem_rsp_valid_i),
        .entry_zero_i  (entry_zero),
        .idle_o        (idle_o),
        .req_valid_o   (mem_req_valid_o),
        .level2_o      (level2),
        .load_o        (load),
        .take_base_o   (take_base),
        .finish_ok_o   (fin_ok),
        .finish_fail_o (fin_fail)
    );

    pt_walk_agen #(
        .PA_W   (PA_W),
        .ENT_W  (ENT_W),
        .L1_W   (L1_W),
        .L2_W   (L2_W),
        .L3_W   (L3_W),
        .EXPAND (EXPAND)
    ) u_agen (
        .root_i      (root_q),
        .base_i      (base_q),
        .level2_i    (level2),
        .idx1_i      (va_q[L1_LO +: L1_W]),
        .idx2_i      (va_q[L2_LO +: L2_W]),
        .idx3_i      (va_q[L3_LO +: L3_W]),
        .entry_i     (mem_rsp_data_i),
        .req_addr_o  (mem_req_addr_o),
        .next_base_o (next_base),
        .leaf_ptr_o  (leaf_ptr)
    );

    // Walk context: the address and root captured on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            root_q <= '0;
        end else if (load) begin
            va_q   <= vaddr_i;
            root_q <= root_i;
        end
    end

    // Second-level base taken from a nonzero first-level entry.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_q <= '0;
        else if (take_base) base_q <= next_base;
    end

    // Result registers: done and fail pulses, plus the held leaf pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            ptr_q  <= '0;
        end else begin
            done_q <= fin_ok || fin_fail;
            fail_q <= fin_fail;
            if (fin_ok)        ptr_q <= leaf_ptr;
            else if (fin_fail) ptr_q <= '0;
        end
    end

    assign walk_va_o  = va_q;
    assign done_o     = done_q;
    assign fail_o     = fail_q;
    assign leaf_ptr_o = ptr_q;

endmodule

// File: rtl/pt_walk_chk.sv
// Property checker for the page table walker, attached with bind.
// Assumes: one response per accepted request and single-cycle responses.
module pt_walk_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            idle_o,
    input logic [VA_W-1:0] walk_va_o,
    input logic            mem_req_valid_o,
    input logic            mem_req_ready_i,
    input logic [PA_W-1:0] mem_req_addr_o,
    input logic            mem_rsp_valid_i,
    input logic            done_o,
    input logic            fail_o
);

    logic pend_q;

    // Tracks whether an accepted request is still waiting for its response.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pend_q <= 1'b0;
        else if (mem_req_valid_o && mem_req_ready_i) pend_q <= 1'b1;
        else if (mem_rsp_valid_i)                    pend_q <= 1'b0;
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_valid_o);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !mem_req_valid_o);

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i) |=> !idle_o);

    assert_va_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o |=> $stable(walk_va_o));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fail_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

endmodule

bind pt_walker pt_walk_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .idle_o          (idle_o),
    .walk_va_o       (walk_va_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .done_o          (done_o),
    .fail_o          (fail_o)
);

// File: tb/sim_pt_walker.sv
// Directed bench for pt_walker. One task per scenario; a memory model
// answers requests with programmed entries after a stall and a latency.
module sim_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] vaddr_i = '0;
    logic [63:0] root_i = '0;
    logic        idle_o, mem_req_valid_o, done_o, fail_o;
    logic [63:0] walk_va_o, mem_req_addr_o, leaf_ptr_o;
    logic        mem_req_ready_i = 1'b0;
    logic        mem_rsp_valid_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;

    int checks = 0;
    int failures = 0;

    logic [31:0] resp_q [0:1];
    logic [63:0] req_log [0:3];
    int nreq = 0;
    int stall_n = 0;
    int lat_n = 1;

    always #4 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .root_i(root_i), .idle_o(idle_o), .walk_va_o(walk_va_o),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .done_o(done_o), .fail_o(fail_o),
        .leaf_ptr_o(leaf_ptr_o)
    );

    // Memory model: stall, accept, wait for the latency, then a one-cycle response.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            if (mem_req_valid_o) begin
                repeat (stall_n) @(negedge clk);
                mem_req_ready_i = 1'b1;
                if (nreq < 4) req_log[nreq] = mem_req_addr_o;
                nreq++;
                @(negedge clk);
                mem_req_ready_i = 1'b0;
                repeat (lat_n - 1) @(negedge clk);
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i  = resp_q[(nreq - 1) % 2];
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] x1(input logic [63:0] va); return (va >> 34) & 64'h7FF; endfunction
    function automatic logic [63:0] x2(input logic [63:0] va); return (va >> 23) & 64'h7FF; endfunction
    function automatic logic [63:0] x3(input logic [63:0] va); return (va >> 13) & 64'h3FF; endfunction

    // Runs a walk. If poke is set, a start with another address is driven mid-walk.
    task automatic run_walk(input logic [63:0] va, input logic [63:0] root, input bit poke,
                            output logic fl, output logic [63:0] ptr, output bit va_ok);
        nreq = 0;
        va_ok = 1'b1;
        @(negedge clk);
        start_i = 1'b1; vaddr_i = va; root_i = root;
        @(negedge clk);
        start_i = 1'b0;
        vaddr_i = ~va; root_i = ~root;
        for (int i = 0; i < 300; i++) begin
            if (done_o) break;
            if (walk_va_o !== va) va_ok = 1'b0;
            start_i = poke && (i == 2);
            @(negedge clk);
        end
        start_i = 1'b0;
        fl  = fail_o;
        ptr = leaf_ptr_o;
        check("R10 done seen", {63'd0, done_o}, 64'd1);
        @(negedge clk);
        check("R10 done one cycle", {62'd0, done_o, fail_o}, 64'd0);
    endtask

    task automatic t_reset;
        check("R1 idle", {63'd0, idle_o}, 64'd1);
        check("R1 req", {63'd0, mem_req_valid_o}, 64'd0);
        check("R1 done", {63'd0, done_o}, 64'd0);
    endtask

    task automatic t_ok(input logic [63:0] va, input logic [63:0] root,
                        input logic [31:0] e1, input logic [31:0] e2, input int st, input int lt);
        logic fl; logic [63:0] ptr; bit vok;
        resp_q[0] = e1; resp_q[1] = e2; stall_n = st; lat_n = lt;
        run_walk(va, root, 1'b0, fl, ptr, vok);
        check("R3 first addr", req_log[0], root + (x1(va) << 2));
        check("R4 second addr", req_log[1], ({32'd0, e1} << 11) + (x2(va) << 2));
        check("R5 ptr", ptr, ({32'd0, e2} << 11) + (x3(va) << 3));
        check("R5 no fail", {63'd0, fl}, 64'd0);
        check("R5 two reads", 64'(nreq), 64'd2);
        check("R9 va held", {63'd0, vok}, 64'd1);
    endtask

    task automatic t_fail1;
        logic fl; logic [63:0] ptr; bit vok;
        resp_q[0] = 32'd0; resp_q[1] = 32'h1234; stall_n = 0; lat_n = 2;
        run_walk(64'h0000_0ABC_DEF0_1000, 64'h8000, 1'b0, fl, ptr, vok);
        check("R6 fail", {63'd0, fl}, 64'd1);
        check("R6 ptr zero", ptr, 64'd0);
        check("R6 one read", 64'(nreq), 64'd1);
    endtask

    task automatic t_fail2;
        logic fl; logic [63:0] ptr; bit vok;
        resp_q[0] = 32'h0004_0001; resp_q[1] = 32'd0; stall_n = 1; lat_n = 1;
        run_walk(64'h0000_1FFF_FFFF_E000, 64'h10_0000, 1'b0, fl, ptr, vok);
        check("R7 fail", {63'd0, fl}, 64'd1);
        check("R7 ptr zero", ptr, 64'd0);
        check("R7 two reads", 64'(nreq), 64'd2);
    endtask

    task automatic t_busy_start;
        logic fl; logic [63:0] ptr; bit vok;
        logic [63:0] va = 64'h0000_0555_AAAA_6000;
        logic [63:0] root = 64'h4_0000;
        resp_q[0] = 32'h0000_7777; resp_q[1] = 32'h0001_2345; stall_n = 0; lat_n = 3;
        run_walk(va, root, 1'b1, fl, ptr, vok);
        check("R2 first addr", req_log[0], root + (x1(va) << 2));
        check("R2 second addr", req_log[1], (64'h7777 << 11) + (x2(va) << 2));
        check("R2 ptr", ptr, (64'h1_2345 << 11) + (x3(va) << 3));
        check("R2 reads", 64'(nreq), 64'd2);
        check("R9 va held busy", {63'd0, vok}, 64'd1);
        repeat (3) @(negedge clk);
        check("R2 no restart", {62'd0, idle_o, mem_req_valid_o}, 64'd2);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ok(64'h0000_1234_5678_9ABC, 64'h20_0000, 32'h0000_0C01, 32'h0000_0D02, 0, 1);
        t_ok(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF, 32'h8000_0000, 3, 2);
        t_ok(64'h0000_0000_0000_0000, 64'hABC0, 32'h1, 32'h1, 2, 4);
        t_fail1();
        t_fail2();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule